// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the transmit half of a clock-synchronous serial port. Software writes a byte into a holding register. When the shifter is free, the byte moves into a shift register and goes out least significant bit first on a single data line. Because there are two registers, software can queue the next byte while the current one is still being sent. If a byte is waiting when a frame finishes, the next frame follows with no idle gap.

As clock master, the block makes its own serial clock from the system clock through a programmable half-period divider. As clock slave, it shifts data on an external serial clock, which first passes through a synchronizer. The serial clock idles high and data changes on falling edges.

A small register port gives software the controls: transmit enable, the two interrupt enables and the clock-master select. It also reports the flags: holding empty, transmit end, overrun and busy. Two interrupt requests come from these flags. An overrun flag raised by the companion receive path stops any new frame from starting until software clears it.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, sckOut and sdo are 1, both interrupt requests are 0, and the status register (address 2) reads 0x01: bit0 empty=1, bit1 end=0, bit2 overrun=0, bit3 busy=0. The control (address 1) and divider (address 3) registers read 0.
- R2: A write to the data register (address 0) while transmit enable (control bit0) is 1 stores the byte and clears empty. On the next clock edge, if overrun is 0 and the shifter is idle, the byte moves to the shifter and empty returns to 1 while busy becomes 1. A data write while transmit enable is 0 is ignored: empty, end and the held byte stay unchanged.
- R3: In master mode (control bit3=1), each bit lasts H cycles with sckOut low followed by H cycles with sckOut high, where H = divider value + 1. Bits go out LSB first. sdo changes only together with a falling sckOut.
- R4: If empty is 0 when the last bit of a frame ends, the held byte loads at that edge and its first bit starts immediately. sckOut does not stay high beyond the normal H cycles between the two frames.
- R5: When the last bit ends with empty=1, the end flag (status bit1) becomes 1 and holds. An accepted data write clears it. A status write with bit1=0 also clears it, and a write with bit1=1 has no effect on it.
- R6: txiReq equals empty AND the empty-interrupt enable (control bit1).
- R7: teiReq equals the end flag AND the end-interrupt enable (control bit2).
- R8: Whenever no frame is in progress, sckOut and sdo are both 1.
- R9: A pulse on ovrSet sets the overrun flag (status bit2). While it is 1, no frame starts and empty stays 0 if a byte is held. A status write with bit2=0 clears it, after which the held byte starts.
- R10: In slave mode (control bit3=0), sckOut stays 1. Each synchronized rising edge of sckIn completes a bit. The next bit appears on sdo at the following synchronized falling edge. The 8th rising edge ends the frame, with reload or the end flag as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 data, 1 control, 2 status, 3 divider |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map as wrAddr |
| rdData | output | 8 | Combinational read data |
| ovrSet | input | 1 | Overrun report from the receive path |
| sckIn | input | 1 | External serial clock (slave mode) |
| sckOut | output | 1 | Serial clock output, idles high |
| sdo | output | 1 | Serial data output |
| txiReq | output | 1 | Holding-empty interrupt request |
| teiReq | output | 1 | Transmit-end interrupt request |

## Verification
Master-mode frames run with a one-cycle half period and with a three-cycle half period. Comparing the two shows that the divider sets the length of both the low and the high phase. A byte queued during an active frame is set against a lone byte: the first pattern must reload with no gap, and the second must raise the end flag. A held byte is also checked with transmit disabled and with overrun set, which separates a write that is ignored from a start that is blocked. Slave mode is driven with a slow external clock for two back-to-back bytes, to check that the clock is synchronized and that data changes only on falling edges.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_DIV  = 2'd3
  } sstReg_e;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic capHold;    // store CPU byte in the holding register
    logic loadShift;  // move holding byte into the shifter
    logic shiftOut;   // advance the shifter by one bit
  } sstStrobe_t;

endpackage

// File: rtl/sst_sync.sv
`timescale 1ns/1ps
module sst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stageQ;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= g_stage[i-1].stageQ;
      end
    end
  end

  assign q = g_stage[STAGES-1].stageQ;

endmodule

// File: rtl/sst_dp.sv
`timescale 1ns/1ps
module sst_dp
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sstStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  output logic [DATA_W-1:0] holdQ,
  output logic              sdo
);

  logic [DATA_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strobe.capHold) begin
      holdQ <= wrData;
    end
  end

  // The load reads the old holding byte, so a write on the same edge is safe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
    end else if (strobe.loadShift) begin
      shiftQ <= holdQ;
    end else if (strobe.shiftOut) begin
      shiftQ <= {1'b1, shiftQ[DATA_W-1:1]};
    end
  end

  assign sdo = busy ? shiftQ[0] : 1'b1;

endmodule

// File: rtl/sst_ctrl.sv
`timescale 1ns/1ps
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] holdQ,
  input  logic              ovrSet,
  input  logic              sckIn,
  output sstStrobe_t        strobe,
  output logic              sckOut,
  output logic              busy,
  output logic              empty,
  output logic              tend,
  output logic              ovr,
  output logic              txEn,
  output logic              txiEn,
  output logic              teiEn,
  output logic              master
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] halfCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             hiPhase;
  logic             advPend;
  logic             sckQ;
  logic             sckSync;
  logic             sckPrev;

  logic dataWr, ctrlWr, statWr, divWr;
  logic canLoad, lastBit, halfDone, sckRise, sckFall;
  logic endFrame, loadGo, shiftGo;

  sst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (sckIn),
    .q    (sckSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b1;
    else       sckPrev <= sckSync;
  end

  always_comb begin
    dataWr   = wrEn && (wrAddr == REG_DATA) && txEn;
    ctrlWr   = wrEn && (wrAddr == REG_CTRL);
    statWr   = wrEn && (wrAddr == REG_STAT);
    divWr    = wrEn && (wrAddr == REG_DIV);
    canLoad  = !empty && txEn && !ovr;
    lastBit  = (bitIdx == LAST_BIT);
    halfDone = (halfCnt == divQ);
    sckRise  = sckSync && !sckPrev;
    sckFall  = !sckSync && sckPrev;
    if (master) begin
      endFrame = busy && halfDone && hiPhase && lastBit;
      shiftGo  = busy && halfDone && hiPhase && !lastBit;
    end else begin
      endFrame = busy && sckRise && lastBit;
      shiftGo  = busy && sckFall && advPend;
    end
    loadGo = canLoad && (!busy || endFrame);
    strobe.capHold   = dataWr;
    strobe.loadShift = loadGo;
    strobe.shiftOut  = shiftGo;
  end

  // Frame sequencing and serial clock generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
      halfCnt <= '0;
      hiPhase <= 1'b0;
      advPend <= 1'b0;
      sckQ    <= 1'b1;
    end else if (loadGo) begin
      busy    <= 1'b1;
      bitIdx  <= '0;
      halfCnt <= '0;
      hiPhase <= 1'b0;
      advPend <= 1'b0;
      sckQ    <= !master;
    end else if (endFrame) begin
      busy <= 1'b0;
      sckQ <= 1'b1;
    end else if (busy) begin
      if (master) begin
        if (halfDone) begin
          halfCnt <= '0;
          hiPhase <= !hiPhase;
          sckQ    <= !hiPhase;
          if (hiPhase) bitIdx <= bitIdx + 1'b1;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end else begin
        if (sckRise) advPend <= 1'b1;
        if (shiftGo) begin
          advPend <= 1'b0;
          bitIdx  <= bitIdx + 1'b1;
        end
      end
    end
  end

  // Flags; CPU writes take effect after the frame logic on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      empty <= 1'b1;
      tend  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (loadGo) empty <= 1'b1;
      if (endFrame && !canLoad && empty) tend <= 1'b1;
      if (dataWr) begin
        empty <= 1'b0;
        tend  <= 1'b0;
      end
      if (statWr && !wrData[1]) tend <= 1'b0;
      if (statWr && !wrData[2]) ovr  <= 1'b0;
      if (ovrSet) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn   <= 1'b0;
      txiEn  <= 1'b0;
      teiEn  <= 1'b0;
      master <= 1'b0;
      divQ   <= '0;
    end else begin
      if (ctrlWr) begin
        txEn   <= wrData[0];
        txiEn  <= wrData[1];
        teiEn  <= wrData[2];
        master <= wrData[3];
      end
      if (divWr) divQ <= wrData[DIV_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      REG_DATA: rdData = holdQ;
      REG_CTRL: rdData[3:0] = {master, teiEn, txiEn, txEn};
      REG_STAT: rdData[3:0] = {busy, ovr, tend, empty};
      REG_DIV:  rdData[DIV_W-1:0] = divQ;
      default:  rdData = '0;
    endcase
  end

  assign sckOut = sckQ;

endmodule

// File: rtl/sync_ser_tx.sv
`timescale 1ns/1ps
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              ovrSet,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sdo,
  output logic              txiReq,
  output logic              teiReq
);

  sstStrobe_t        strobe;
  logic [DATA_W-1:0] holdQ;
  logic busyW, emptyW, tendW, ovrW, txEnW, txiEnW, teiEnW, masterW;

  sst_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .holdQ  (holdQ),
    .ovrSet (ovrSet),
    .sckIn  (sckIn),
    .strobe (strobe),
    .sckOut (sckOut),
    .busy   (busyW),
    .empty  (emptyW),
    .tend   (tendW),
    .ovr    (ovrW),
    .txEn   (txEnW),
    .txiEn  (txiEnW),
    .teiEn  (teiEnW),
    .master (masterW)
  );

  sst_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .busy   (busyW),
    .holdQ  (holdQ),
    .sdo    (sdo)
  );

  assign txiReq = emptyW && txiEnW;
  assign teiReq = tendW && teiEnW;

endmodule

// File: rtl/sst_chk.sv
`timescale 1ns/1ps
module sst_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       sckOut,
  input logic       sdo,
  input logic       txiReq,
  input logic       busy,
  input logic       empty,
  input logic       tend,
  input logic       ovr,
  input logic       txEn,
  input logic       master
);

  logic dataWrite;
  assign dataWrite = wrEn && (wrAddr == 2'd0) && txEn;

  // R8: idle line is high on both clock and data
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sckOut && sdo));

  // R2: a frame start always leaves the holding register empty
  assert_load_empties_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> empty);

  // R6: an accepted data write withdraws the empty request
  assert_write_drops_txi_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> !txiReq);

  // R5: end flag holds unless software writes
  assert_tend_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tend && !wrEn) |=> tend);

  // R9: no frame starts while overrun is set
  assert_ovr_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && !busy) |=> !busy);

  // R3: in master mode data moves only with a low serial clock
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (master && $past(master) && busy && $past(busy) && !$stable(sdo)) |-> !sckOut);

  // R10: slave mode never drives the serial clock low
  assert_slave_clock_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!master && $past(!master) && $past(sckOut)) |-> sckOut);

endmodule

bind sync_ser_tx sst_chk u_sst_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .sckOut (sckOut),
  .sdo    (sdo),
  .txiReq (txiReq),
  .busy   (busyW),
  .empty  (emptyW),
  .tend   (tendW),
  .ovr    (ovrW),
  .txEn   (txEnW),
  .master (masterW)
);

// File: tb/test_sync_ser_tx.sv
`timescale 1ns/1ps
module test_sync_ser_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ovrSet = 1'b0;
  logic       sckIn = 1'b1;
  logic       sckOut, sdo, txiReq, teiReq;

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 0;
  string lineTag = "R1";

  always #2.5 clk = ~clk;

  sync_ser_tx i_sync_ser_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ovrSet(ovrSet), .sckIn(sckIn),
    .sckOut(sckOut), .sdo(sdo), .txiReq(txiReq), .teiReq(teiReq)
  );

  // Behavioural reference model
  int  mHold, mShift, mDiv, mTick, mBit;
  bit  mTe, mTxie, mTeie, mMaster;
  bit  mEmpty, mEnd, mOvr, mBusy, mHigh, mAdv, mSck;
  bit  sy1, sy2, sy3;

  always @(posedge clk) begin
    if (!rstN) begin
      mHold = 0; mShift = 255; mDiv = 0; mTick = 0; mBit = 0;
      mTe = 0; mTxie = 0; mTeie = 0; mMaster = 0;
      mEmpty = 1; mEnd = 0; mOvr = 0; mBusy = 0; mHigh = 0; mAdv = 0; mSck = 1;
      sy1 = 1; sy2 = 1; sy3 = 1;
    end else begin
      bit rise, fall, ready, startNow, frameDone;
      rise = sy2 && !sy3;
      fall = !sy2 && sy3;
      sy3 = sy2; sy2 = sy1; sy1 = sckIn;
      ready = !mEmpty && mTe && !mOvr;
      startNow = 0;
      frameDone = 0;
      if (!mBusy) begin
        startNow = ready;
      end else if (mMaster) begin
        if (mTick == mDiv) begin
          mTick = 0;
          if (!mHigh) begin
            mHigh = 1; mSck = 1;
          end else begin
            mHigh = 0;
            if (mBit < 7) begin
              mBit++; mShift = (mShift >> 1) | 128; mSck = 0;
            end else frameDone = 1;
          end
        end else mTick++;
      end else begin
        if (rise) begin
          if (mBit == 7) frameDone = 1;
          else mAdv = 1;
        end
        if (fall && mAdv) begin
          mShift = (mShift >> 1) | 128; mBit++; mAdv = 0;
        end
      end
      if (frameDone) begin
        if (ready) startNow = 1;
        else begin
          mBusy = 0; mSck = 1;
          if (mEmpty) mEnd = 1;
        end
      end
      if (startNow) begin
        mShift = mHold; mEmpty = 1; mBusy = 1; mBit = 0; mTick = 0;
        mHigh = 0; mAdv = 0; mSck = !mMaster;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: if (mTe) begin mHold = wrData; mEmpty = 0; mEnd = 0; end
          2'd1: begin
            mTe = wrData[0]; mTxie = wrData[1]; mTeie = wrData[2]; mMaster = wrData[3];
          end
          2'd2: begin
            if (!wrData[1]) mEnd = 0;
            if (!wrData[2]) mOvr = 0;
          end
          default: mDiv = wrData;
        endcase
      end
      if (ovrSet) mOvr = 1;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expSdo;
      expSdo = mBusy ? mShift[0] : 1'b1;
      compared++;
      if (sckOut !== mSck || sdo !== expSdo) begin
        mismatched++;
        $display("FAIL %s line: sck=%0b sdo=%0b expected sck=%0b sdo=%0b at %0t",
                 lineTag, sckOut, sdo, mSck, expSdo, $time);
      end
      compared++;
      if (txiReq !== (mEmpty && mTxie)) begin
        mismatched++;
        $display("FAIL R6 txiReq=%0b expected %0b at %0t", txiReq, mEmpty && mTxie, $time);
      end
      compared++;
      if (teiReq !== (mEnd && mTeie)) begin
        mismatched++;
        $display("FAIL R7 teiReq=%0b expected %0b at %0t", teiReq, mEnd && mTeie, $time);
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic regWrite(logic [1:0] addr, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] addr, logic [7:0] exp, string req, string what);
    rdAddr = addr;
    #0.5;
    check(req, rdData, exp, what);
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slaveClocks(int pulses);
    for (int p = 0; p < pulses; p++) begin
      repeat (4) @(negedge clk);
      sckIn = 1'b0;
      repeat (4) @(negedge clk);
      sckIn = 1'b1;
    end
  endtask

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R1: reset state
    regRead(2'd2, 8'h01, "R1", "status after reset");
    regRead(2'd1, 8'h00, "R1", "control after reset");
    regRead(2'd3, 8'h00, "R1", "divider after reset");
    check("R1", {4'h0, sckOut, sdo, txiReq, teiReq}, 8'h0C, "pins after reset");

    // R2 / R3: single master frame, H = 1
    lineTag = "R3";
    regWrite(2'd1, 8'h0F);
    regWrite(2'd0, 8'hA5);
    regRead(2'd2, 8'h00, "R2", "status with byte held");
    waitCycles(1);
    regRead(2'd2, 8'h09, "R2", "status after load");
    check("R6", {7'h0, txiReq}, 8'h01, "txiReq after load");

    // R4: queue a byte during the frame
    lineTag = "R4";
    regWrite(2'd0, 8'h3C);
    waitCycles(40);
    regRead(2'd2, 8'h03, "R5", "status after back-to-back pair");
    regRead(2'd0, 8'h3C, "R2", "holding readback");
    check("R7", {7'h0, teiReq}, 8'h01, "teiReq at end");

    // R5: clearing the end flag
    regWrite(2'd2, 8'h02);
    regRead(2'd2, 8'h03, "R5", "status after write of 1 to end bit");
    regWrite(2'd2, 8'h00);
    regRead(2'd2, 8'h01, "R5", "status after write of 0 to end bit");
    check("R7", {7'h0, teiReq}, 8'h00, "teiReq after clear");

    // R3: slower divider, H = 3
    lineTag = "R3";
    regWrite(2'd3, 8'h02);
    regWrite(2'd0, 8'h96);
    waitCycles(60);
    regRead(2'd2, 8'h03, "R3", "status after slow frame");
    check("R8", {6'h0, sckOut, sdo}, 8'h03, "idle pins");

    // R2: data write ignored with transmit disabled
    lineTag = "R2";
    regWrite(2'd1, 8'h0E);
    regWrite(2'd0, 8'h11);
    regRead(2'd2, 8'h03, "R2", "status after ignored write");
    regRead(2'd0, 8'h96, "R2", "holding after ignored write");

    // R9: overrun blocks a start
    lineTag = "R9";
    regWrite(2'd3, 8'h00);
    regWrite(2'd1, 8'h0F);
    @(negedge clk); ovrSet = 1'b1;
    @(negedge clk); ovrSet = 1'b0;
    regRead(2'd2, 8'h07, "R9", "status with overrun");
    regWrite(2'd0, 8'hC3);
    regRead(2'd2, 8'h04, "R5", "end flag cleared by data write");
    waitCycles(20);
    regRead(2'd2, 8'h04, "R9", "status while blocked");
    check("R9", {7'h0, sckOut}, 8'h01, "sck while blocked");
    regWrite(2'd2, 8'h00);
    waitCycles(30);
    regRead(2'd2, 8'h03, "R9", "status after overrun cleared");

    // R10: slave mode, two back-to-back bytes
    lineTag = "R10";
    regWrite(2'd1, 8'h05);
    regWrite(2'd0, 8'h5A);
    regWrite(2'd0, 8'hE1);
    check("R6", {7'h0, txiReq}, 8'h00, "txiReq with enable off");
    slaveClocks(16);
    waitCycles(5);
    regRead(2'd2, 8'h03, "R10", "status after slave frames");
    check("R10", {7'h0, sckOut}, 8'h01, "sck in slave mode");
    check("R8", {6'h0, sckOut, sdo}, 8'h03, "idle pins after slave");

    waitCycles(2);
    finish();
  end

endmodule